// File: doc/BRIEF.md
# Digital Lock Detector with Hysteresis

This block decides whether a phase-locked loop has settled. Every time the phase detector finishes a comparison, a valid strobe arrives with the absolute phase error, measured in system-clock cycles. The block counts back-to-back comparisons whose error is under a tight limit. Once the run reaches the required length, it raises an active-high lock flag. A mode input selects a required run of three or five comparisons.

The hysteresis is asymmetric. Lock needs a run of fine errors, but one error above a looser limit releases it at once. Errors between the two limits leave a locked detector untouched. A synchronous reset or a configuration-clear pulse, issued whenever the divider settings are rewritten, drops lock and discards any partial run. Both limits and both run lengths are parameters.

Top module: `dlock_det`

## Requirements
- R1: `locked_o` is active high. A synchronous `rst` (active high) forces `locked_o` to 0 and discards any partial run of fine comparisons.
- R2: With `long_mode_i` = 0, `locked_o` rises on the clock edge that samples the third consecutive valid comparison whose `phase_err_i` is strictly below `FINE_LIM` (default 3). It stays low after the first and second.
- R3: With `long_mode_i` = 1, `locked_o` rises on the edge that samples the fifth such consecutive comparison. It stays low after the first four.
- R4: While unlocked, a valid comparison with `phase_err_i` >= `FINE_LIM` (the value 3 included) restarts the run from zero, so a complete new run is needed before lock.
- R5: Clock cycles with `cmp_valid_i` low neither advance nor break a run and never change `locked_o`, whatever `phase_err_i` holds.
- R6: While locked, a valid comparison with `phase_err_i` strictly above `GROSS_LIM` (default 5) clears `locked_o` on that edge. A complete new run is then needed to lock again.
- R7: While locked, valid comparisons with `phase_err_i` <= `GROSS_LIM` keep `locked_o` high. This includes errors between the two limits, for example 3, 4 and 5.
- R8: A `cfg_clear_i` pulse clears `locked_o` and the partial run. It takes priority over a comparison presented in the same cycle.
- R9: The run length needed is taken from `long_mode_i` as sampled with each comparison. A run partly built in one mode completes as soon as its length reaches the count for the current mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_clear_i | input | 1 | Pulse sent on any divider reconfiguration; clears lock and run |
| cmp_valid_i | input | 1 | One-cycle strobe marking a finished phase comparison |
| long_mode_i | input | 1 | 0: run of SHORT_RUN needed; 1: run of LONG_RUN needed |
| phase_err_i | input | ERR_W | Absolute phase error of the comparison, in clock cycles |
| locked_o | output | 1 | Lock flag, active high |

## Verification
Every result is due on the first rising edge after the stimulus. The state register samples the strobe, the clear or the reset at that edge, and `locked_o` comes straight from that register. The bench changes inputs only on falling edges and holds each one for exactly one cycle. It reads `locked_o` at the next falling edge, half a period after the edge that must have updated it. Run-length checks sample after each comparison in turn, so a lock that comes one comparison early or late fails at the exact comparison where it occurs.

// File: rtl/dld_pkg.sv
package dld_pkg;

    // Classification of one phase-error sample against the two limits.
    typedef enum logic [1:0] {
        BAND_FINE  = 2'd0,   // below the tight limit: counts toward lock
        BAND_MID   = 2'd1,   // between limits: breaks a run, keeps a lock
        BAND_GROSS = 2'd2    // above the loose limit: releases a lock
    } err_band_e;

endpackage

// File: rtl/dld_err_band.sv
module dld_err_band
    import dld_pkg::*;
#(
    parameter int ERR_W     = 8,
    parameter int FINE_LIM  = 3,
    parameter int GROSS_LIM = 5
) (
    input  logic [ERR_W-1:0] err_i,
    output err_band_e        band_o
);

    localparam logic [ERR_W-1:0] FINE_V  = ERR_W'(FINE_LIM);
    localparam logic [ERR_W-1:0] GROSS_V = ERR_W'(GROSS_LIM);

    always_comb begin
        if (err_i < FINE_V) begin
            band_o = BAND_FINE;
        end else if (err_i > GROSS_V) begin
            band_o = BAND_GROSS;
        end else begin
            band_o = BAND_MID;
        end
    end

endmodule

// File: rtl/dld_run_target.sv
module dld_run_target #(
    parameter int CNT_W     = 3,
    parameter int SHORT_RUN = 3,
    parameter int LONG_RUN  = 5
) (
    input  logic             long_mode_i,
    output logic [CNT_W-1:0] target_o
);

    localparam logic [CNT_W-1:0] SHORT_V = CNT_W'(SHORT_RUN);
    localparam logic [CNT_W-1:0] LONG_V  = CNT_W'(LONG_RUN);

    assign target_o = long_mode_i ? LONG_V : SHORT_V;

endmodule

// File: rtl/dld_core.sv
module dld_core
    import dld_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic             valid_i,
    input  err_band_e        band_i,
    input  logic [CNT_W-1:0] target_i,
    output logic             locked_o
);

    localparam logic [CNT_W-1:0] RUN_MAX = '1;

    typedef struct packed {
        logic             locked;
        logic [CNT_W-1:0] run;
    } state_t;

    state_t st_d;
    state_t st_q;
    logic [CNT_W-1:0] run_inc_d;

    always_comb begin
        st_d      = st_q;
        run_inc_d = (st_q.run == RUN_MAX) ? st_q.run : st_q.run + 1'b1;

        if (clear_i) begin
            st_d = '0;
        end else if (valid_i) begin
            if (st_q.locked) begin
                // Only a gross error releases; mid and fine errors change nothing.
                if (band_i == BAND_GROSS) begin
                    st_d.locked = 1'b0;
                    st_d.run    = '0;
                end
            end else if (band_i == BAND_FINE) begin
                if (run_inc_d >= target_i) begin
                    st_d.locked = 1'b1;
                    st_d.run    = '0;
                end else begin
                    st_d.run = run_inc_d;
                end
            end else begin
                st_d.run = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign locked_o = st_q.locked;

endmodule

// File: rtl/dlock_det.sv
module dlock_det
    import dld_pkg::*;
#(
    parameter int ERR_W     = 8,
    parameter int FINE_LIM  = 3,
    parameter int GROSS_LIM = 5,
    parameter int SHORT_RUN = 3,
    parameter int LONG_RUN  = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_clear_i,
    input  logic             cmp_valid_i,
    input  logic             long_mode_i,
    input  logic [ERR_W-1:0] phase_err_i,
    output logic             locked_o
);

    localparam int MAX_RUN = (LONG_RUN > SHORT_RUN) ? LONG_RUN : SHORT_RUN;
    localparam int CNT_W   = $clog2(MAX_RUN + 1);

    err_band_e        band;
    logic [CNT_W-1:0] target;

    dld_err_band #(
        .ERR_W    (ERR_W),
        .FINE_LIM (FINE_LIM),
        .GROSS_LIM(GROSS_LIM)
    ) u_band (
        .err_i (phase_err_i),
        .band_o(band)
    );

    dld_run_target #(
        .CNT_W    (CNT_W),
        .SHORT_RUN(SHORT_RUN),
        .LONG_RUN (LONG_RUN)
    ) u_target (
        .long_mode_i(long_mode_i),
        .target_o   (target)
    );

    dld_core #(
        .CNT_W(CNT_W)
    ) u_core (
        .clk     (clk),
        .rst     (rst),
        .clear_i (cfg_clear_i),
        .valid_i (cmp_valid_i),
        .band_i  (band),
        .target_i(target),
        .locked_o(locked_o)
    );

endmodule

// File: rtl/dlock_det_chk.sv
module dlock_det_chk #(
    parameter int ERR_W     = 8,
    parameter int FINE_LIM  = 3,
    parameter int GROSS_LIM = 5,
    parameter int SHORT_RUN = 3,
    parameter int LONG_RUN  = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_clear_i,
    input logic             cmp_valid_i,
    input logic             long_mode_i,
    input logic [ERR_W-1:0] phase_err_i,
    input logic             locked_o
);

    localparam int CW = 8;

    logic          fine;
    logic          gross;
    logic [CW-1:0] need;
    logic [CW-1:0] ck_run;
    logic [CW-1:0] ck_next;

    assign fine    = int'(phase_err_i) < FINE_LIM;
    assign gross   = int'(phase_err_i) > GROSS_LIM;
    assign need    = long_mode_i ? CW'(LONG_RUN) : CW'(SHORT_RUN);
    assign ck_next = (ck_run == '1) ? ck_run : ck_run + 1'b1;

    // Independent tally of the fine comparisons seen while unlocked.
    always_ff @(posedge clk) begin
        if (rst || cfg_clear_i) begin
            ck_run <= '0;
        end else if (cmp_valid_i) begin
            if (locked_o || !fine) begin
                ck_run <= '0;
            end else begin
                ck_run <= ck_next;
            end
        end
    end

    assert_clear_drops_R8: assert property (@(posedge clk) disable iff (rst)
        cfg_clear_i |=> !locked_o);

    assert_gross_release_R6: assert property (@(posedge clk) disable iff (rst)
        locked_o && cmp_valid_i && gross && !cfg_clear_i |=> !locked_o);

    assert_mid_holds_R7: assert property (@(posedge clk) disable iff (rst)
        locked_o && cmp_valid_i && !gross && !cfg_clear_i |=> locked_o);

    assert_idle_stable_R5: assert property (@(posedge clk) disable iff (rst)
        !cmp_valid_i && !cfg_clear_i |=> $stable(locked_o));

    assert_no_early_lock_R2: assert property (@(posedge clk) disable iff (rst)
        !locked_o && cmp_valid_i && fine && !cfg_clear_i && (ck_next < need)
        |=> !locked_o);

    assert_lock_on_run_R9: assert property (@(posedge clk) disable iff (rst)
        !locked_o && cmp_valid_i && fine && !cfg_clear_i && (ck_next >= need)
        |=> locked_o);

    assert_coarse_blocks_R4: assert property (@(posedge clk) disable iff (rst)
        !locked_o && cmp_valid_i && !fine |=> !locked_o);

    assert_rise_cause_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(locked_o) |-> $past(cmp_valid_i) && !$past(cfg_clear_i));

endmodule

bind dlock_det dlock_det_chk #(
    .ERR_W    (ERR_W),
    .FINE_LIM (FINE_LIM),
    .GROSS_LIM(GROSS_LIM),
    .SHORT_RUN(SHORT_RUN),
    .LONG_RUN (LONG_RUN)
) u_chk (.*);

// File: tb/dlock_det_tb.sv
module dlock_det_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_clear_i = 1'b0;
    logic       cmp_valid_i = 1'b0;
    logic       long_mode_i = 1'b0;
    logic [7:0] phase_err_i = '0;
    logic       locked_o;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dlock_det u_dut (
        .clk        (clk),
        .rst        (rst),
        .cfg_clear_i(cfg_clear_i),
        .cmp_valid_i(cmp_valid_i),
        .long_mode_i(long_mode_i),
        .phase_err_i(phase_err_i),
        .locked_o   (locked_o)
    );

    task automatic expect_lock(input string tag, input logic exp);
        total++;
        if (locked_o !== exp) begin
            bad++;
            $display("FAIL %s: locked_o=%0b expected=%0b", tag, locked_o, exp);
        end
    endtask

    // One comparison, held for a single cycle; returns at the next falling edge.
    task automatic compare(input int err);
        @(negedge clk);
        cmp_valid_i = 1'b1;
        phase_err_i = 8'(err);
        @(negedge clk);
        cmp_valid_i = 1'b0;
        phase_err_i = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        expect_lock("R1 reset state", 1'b0);
        long_mode_i = 1'b0;
        compare(0);
        compare(1);
        do_reset();
        expect_lock("R1 reset mid-run", 1'b0);
        compare(0);
        compare(0);
        expect_lock("R1 run discarded by reset", 1'b0);
        compare(2);
        expect_lock("R1 fresh run locks", 1'b1);
        do_reset();
        expect_lock("R1 reset drops lock", 1'b0);
    endtask

    task automatic t_short();
        do_reset();
        long_mode_i = 1'b0;
        compare(1);
        expect_lock("R2 after 1st fine", 1'b0);
        compare(0);
        expect_lock("R2 after 2nd fine", 1'b0);
        compare(2);
        expect_lock("R2 after 3rd fine", 1'b1);
    endtask

    task automatic t_long();
        do_reset();
        long_mode_i = 1'b1;
        for (int i = 1; i <= 4; i++) begin
            compare(i % 3);
            expect_lock($sformatf("R3 after fine %0d", i), 1'b0);
        end
        compare(2);
        expect_lock("R3 after 5th fine", 1'b1);
        long_mode_i = 1'b0;
    endtask

    task automatic t_break();
        do_reset();
        long_mode_i = 1'b0;
        compare(0);
        compare(0);
        compare(3);
        expect_lock("R4 boundary error 3", 1'b0);
        compare(0);
        compare(0);
        expect_lock("R4 run restarted", 1'b0);
        compare(0);
        expect_lock("R4 lock after new run", 1'b1);
    endtask

    task automatic t_gap();
        do_reset();
        long_mode_i = 1'b0;
        compare(0);
        phase_err_i = 8'd200;
        repeat (3) @(negedge clk);
        phase_err_i = '0;
        compare(1);
        expect_lock("R5 idle gap keeps run", 1'b0);
        compare(1);
        expect_lock("R5 lock across gap", 1'b1);
        phase_err_i = 8'd250;
        repeat (4) @(negedge clk);
        phase_err_i = '0;
        expect_lock("R5 idle large error ignored", 1'b1);
    endtask

    task automatic t_hold_release();
        do_reset();
        long_mode_i = 1'b0;
        repeat (3) compare(0);
        expect_lock("R7 locked before band test", 1'b1);
        compare(5);
        expect_lock("R7 error 5 keeps lock", 1'b1);
        compare(4);
        expect_lock("R7 error 4 keeps lock", 1'b1);
        compare(3);
        expect_lock("R7 error 3 keeps lock", 1'b1);
        compare(6);
        expect_lock("R6 error 6 releases", 1'b0);
        compare(0);
        compare(0);
        expect_lock("R6 partial run after release", 1'b0);
        compare(0);
        expect_lock("R6 relock after full run", 1'b1);
        compare(255);
        expect_lock("R6 max error releases", 1'b0);
    endtask

    task automatic t_clear();
        do_reset();
        long_mode_i = 1'b0;
        compare(0);
        compare(0);
        @(negedge clk);
        cfg_clear_i = 1'b1;
        cmp_valid_i = 1'b1;
        phase_err_i = '0;
        @(negedge clk);
        cfg_clear_i = 1'b0;
        cmp_valid_i = 1'b0;
        expect_lock("R8 clear beats comparison", 1'b0);
        compare(0);
        compare(0);
        expect_lock("R8 run discarded by clear", 1'b0);
        compare(0);
        expect_lock("R8 lock after new run", 1'b1);
        @(negedge clk);
        cfg_clear_i = 1'b1;
        @(negedge clk);
        cfg_clear_i = 1'b0;
        expect_lock("R8 clear drops lock", 1'b0);
    endtask

    task automatic t_mode_switch();
        do_reset();
        long_mode_i = 1'b1;
        compare(0);
        compare(0);
        expect_lock("R9 two fine in long mode", 1'b0);
        long_mode_i = 1'b0;
        compare(0);
        expect_lock("R9 short count reached", 1'b1);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_short();
        t_long();
        t_break();
        t_gap();
        t_hold_release();
        t_clear();
        t_mode_switch();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: finished=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule